// File: doc/BRIEF.md
# Processor Clock Divider with Ready Merge and Reset Stretcher

This block turns a stream of timing pulses into the clocks and control levels a small processor system needs. Two pulse sources arrive as single-cycle enables in the system clock domain. One comes from a crystal oscillator and the other from an external frequency input. A select input picks one of them. The selected stream is divided by three to form the processor clock, which is high for one third of its period. That clock is divided by two again to form a peripheral clock with a 50 percent duty cycle. Both clocks are registered levels, and downstream logic uses them as clock-enable patterns.

Two wait-request pairs, each a ready level with an active-low enable, are synchronised and then merged into a single ready output. That output moves only when the processor clock changes level. An active-low reset request is also synchronised. The block raises the processor reset at once and holds it long enough for the processor to see a valid reset.

When the source select changes, the divider waits for the first pulse of the newly chosen source and restarts from the start of a high phase. Because of this, a switch never produces a shortened high phase.

Top module: `cdr_clkgen_top`

## Requirements
- R1: `src_sel` = 0 divides the crystal pulses on `xtal_tick`, and `src_sel` = 1 divides the external pulses on `ext_tick`.
- R2: `cpu_clk` has a period of three selected-source pulse intervals and is high for exactly one of them.
- R3: `per_clk` has a period of six source pulse intervals, is high for three of them, and changes level only while `cpu_clk` is high.
- R4: After synchronisation, the merged ready level is 1 when (`rdy_a`=1 and `en_a_n`=0) or (`rdy_b`=1 and `en_b_n`=0). Otherwise it is 0.
- R5: `ready_out` changes only in a cycle in which `cpu_clk` also changes level.
- R6: A low level on `rst_in_n` drives `reset_out` to 1 within three system clocks. The path is two synchroniser flops plus the output register.
- R7: Once `reset_out` rises, it stays high for at least four rising edges of `cpu_clk`.
- R8: `reset_out` falls only after the synchronised `rst_in_n` has been high across two rising edges of `cpu_clk`, which is one full processor clock.
- R9: After a change of `src_sel`, the divider restarts on the first pulse of the new source. No `cpu_clk` high phase is then shorter than one pulse interval of the source that is selected at that time.
- R10: While `rst_n` is low, `cpu_clk`=0, `per_clk`=0, `ready_out`=0 and `reset_out`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pulses and outputs are in this domain |
| rst_n | input | 1 | Active-low block reset |
| xtal_tick | input | 1 | Crystal-derived source pulse, one cycle wide |
| ext_tick | input | 1 | External-frequency source pulse, one cycle wide |
| src_sel | input | 1 | Source select: 0 crystal, 1 external |
| rdy_a | input | 1 | Ready level, pair A |
| en_a_n | input | 1 | Active-low qualifier, pair A |
| rdy_b | input | 1 | Ready level, pair B |
| en_b_n | input | 1 | Active-low qualifier, pair B |
| rst_in_n | input | 1 | Asynchronous active-low reset request |
| cpu_clk | output | 1 | Processor clock level, divide by three, one-third high |
| per_clk | output | 1 | Peripheral clock level, divide by six, symmetric |
| ready_out | output | 1 | Merged ready, updated on processor clock transitions |
| reset_out | output | 1 | Stretched, synchronised processor reset, active high |

## Verification
The divider is run from a crystal pulse every second cycle and an external pulse every third cycle. The two distinct periods and high widths show which source is in use and that the duty ratio is correct. The ready merge is driven through every qualifying pattern: only A active, only B active, A with its enable high, and both active. These patterns separate an OR of the qualified pairs from an AND, and from a merge that ignores the enables. Two reset scenarios are used. A short request pulse exercises the four-clock minimum. A long hold exercises the one-full-clock release rule. Together they show which of the two limits governs release. A source switch made in the middle of a phase shows whether a sliver of high phase can escape.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
    localparam int CPU_DIV      = 3;
    localparam int SYNC_DEPTH   = 2;
    localparam int RST_MIN_CLKS = 4;
    localparam int RST_HOLD_CLKS = 2;

    typedef enum logic {
        SRC_XTAL = 1'b0,
        SRC_EXT  = 1'b1
    } src_e;
endpackage

// File: rtl/cdr_divider.sv
module cdr_divider
    import cdr_pkg::*;
#(
    parameter int DIV = CPU_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_tick,
    input  logic ext_tick,
    input  logic src_sel,
    output logic cpu_clk,
    output logic per_clk,
    output logic cpu_rise,
    output logic cpu_edge
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] ph;
        logic          cpu;
        logic          per;
        logic          sel;
        logic          pend;
    } div_t;

    div_t q, d;
    logic          tick;
    logic [PW-1:0] ph_nx;

    always_comb begin
        d     = q;
        tick  = (src_e'(src_sel) == SRC_EXT) ? ext_tick : xtal_tick;
        ph_nx = (q.ph == PH_LAST) ? '0 : q.ph + 1'b1;
        d.sel = src_sel;
        if (src_sel != q.sel) begin
            d.pend = 1'b1;
        end
        if (tick) begin
            if (d.pend) begin
                d.ph   = '0;
                d.cpu  = 1'b1;
                d.per  = 1'b1;
                d.pend = 1'b0;
            end else begin
                d.ph  = ph_nx;
                d.cpu = (ph_nx == '0);
                if (ph_nx == '0) begin
                    d.per = ~q.per;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ph   <= PH_LAST;
            q.cpu  <= 1'b0;
            q.per  <= 1'b0;
            q.sel  <= src_sel;
            q.pend <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cpu_clk  = q.cpu;
    assign per_clk  = q.per;
    assign cpu_rise = d.cpu & ~q.cpu;
    assign cpu_edge = d.cpu ^ q.cpu;

    AST_PH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.ph <= PH_LAST); // R2
    AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.cpu) |-> $past(xtal_tick | ext_tick)); // R2
    AST_PER_MOVES_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.per) |-> q.cpu); // R3
    AST_SWITCH_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pend && tick) |=> (q.cpu && q.ph == '0)); // R9
endmodule

// File: rtl/cdr_ready_merge.sv
module cdr_ready_merge
    import cdr_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH,
    parameter int PAIRS  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PAIRS-1:0] rdy,
    input  logic [PAIRS-1:0] en_n,
    input  logic             cpu_edge,
    output logic             ready_out
);
    localparam int W = 2 * PAIRS;

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] sync;
        logic                     rdy;
    } rm_t;

    rm_t q, d;
    logic [W-1:0]     raw;
    logic [W-1:0]     s_out;
    logic [PAIRS-1:0] qual;
    logic             merged;

    assign raw   = {en_n, rdy};
    assign s_out = q.sync[STAGES-1];

    genvar g;
    generate
        for (g = 0; g < PAIRS; g++) begin : g_pair
            assign qual[g] = s_out[g] & ~s_out[PAIRS + g];
        end
    endgenerate

    assign merged = |qual;

    always_comb begin
        d = q;
        d.sync[0] = raw;
        for (int i = 1; i < STAGES; i++) begin
            d.sync[i] = q.sync[i-1];
        end
        if (cpu_edge) begin
            d.rdy = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ready_out = q.rdy;

    AST_RDY_ONLY_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.rdy) |-> $past(cpu_edge)); // R5
    AST_RDY_FOLLOWS_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_edge |=> (q.rdy == $past(merged))); // R4
endmodule

// File: rtl/cdr_reset_stretch.sv
module cdr_reset_stretch
    import cdr_pkg::*;
#(
    parameter int STAGES    = SYNC_DEPTH,
    parameter int MIN_CLKS  = RST_MIN_CLKS,
    parameter int HOLD_CLKS = RST_HOLD_CLKS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_in_n,
    input  logic cpu_rise,
    output logic reset_out
);
    localparam int TW = $clog2(MIN_CLKS + 1);
    localparam int HW = $clog2(HOLD_CLKS + 1);
    localparam logic [TW-1:0] TOT_MAX = TW'(MIN_CLKS);
    localparam logic [HW-1:0] HI_MAX  = HW'(HOLD_CLKS);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              rst;
        logic [TW-1:0]     tot;
        logic [HW-1:0]     hi;
    } rs_t;

    rs_t  q, d;
    logic rin_s;

    assign rin_s = q.sync[STAGES-1];

    always_comb begin
        d = q;
        d.sync = {q.sync[STAGES-2:0], rst_in_n};
        if (!q.rst) begin
            d.tot = '0;
            d.hi  = '0;
        end
        if (!rin_s) begin
            d.rst = 1'b1;
            d.hi  = '0;
        end
        if (cpu_rise && (q.rst || !rin_s)) begin
            if (d.tot != TOT_MAX) d.tot = d.tot + 1'b1;
            if (rin_s && d.hi != HI_MAX) d.hi = d.hi + 1'b1;
        end
        if (q.rst && rin_s && d.hi == HI_MAX && d.tot == TOT_MAX) begin
            d.rst = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= '0;
            q.rst  <= 1'b1;
            q.tot  <= '0;
            q.hi   <= '0;
        end else begin
            q <= d;
        end
    end

    assign reset_out = q.rst;

    AST_RST_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !rin_s |=> q.rst); // R6
    AST_RST_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.rst) |-> ($past(q.tot) >= TW'(MIN_CLKS - 1))); // R7
    AST_RST_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.rst) |-> ($past(rin_s) && $past(q.hi) >= HW'(HOLD_CLKS - 1))); // R8
endmodule

// File: rtl/cdr_clkgen_top.sv
module cdr_clkgen_top
    import cdr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_tick,
    input  logic ext_tick,
    input  logic src_sel,
    input  logic rdy_a,
    input  logic en_a_n,
    input  logic rdy_b,
    input  logic en_b_n,
    input  logic rst_in_n,
    output logic cpu_clk,
    output logic per_clk,
    output logic ready_out,
    output logic reset_out
);
    logic cpu_rise;
    logic cpu_edge;

    cdr_divider #(.DIV(CPU_DIV)) div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .xtal_tick (xtal_tick),
        .ext_tick  (ext_tick),
        .src_sel   (src_sel),
        .cpu_clk   (cpu_clk),
        .per_clk   (per_clk),
        .cpu_rise  (cpu_rise),
        .cpu_edge  (cpu_edge)
    );

    cdr_ready_merge #(.STAGES(SYNC_DEPTH), .PAIRS(2)) rdy_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rdy       ({rdy_b, rdy_a}),
        .en_n      ({en_b_n, en_a_n}),
        .cpu_edge  (cpu_edge),
        .ready_out (ready_out)
    );

    cdr_reset_stretch #(
        .STAGES    (SYNC_DEPTH),
        .MIN_CLKS  (RST_MIN_CLKS),
        .HOLD_CLKS (RST_HOLD_CLKS)
    ) rst_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_in_n  (rst_in_n),
        .cpu_rise  (cpu_rise),
        .reset_out (reset_out)
    );

    AST_READY_WITH_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ready_out) |-> !$stable(cpu_clk)); // R5
endmodule

// File: tb/cdr_clkgen_top_tb_top.sv
module cdr_clkgen_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xtal_tick = 1'b0, ext_tick = 1'b0, src_sel = 1'b0;
    logic rdy_a = 1'b0, en_a_n = 1'b1, rdy_b = 1'b0, en_b_n = 1'b1;
    logic rst_in_n = 1'b1;
    logic cpu_clk, per_clk, ready_out, reset_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cdr_clkgen_top dut_i (
        .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .ext_tick(ext_tick),
        .src_sel(src_sel), .rdy_a(rdy_a), .en_a_n(en_a_n), .rdy_b(rdy_b),
        .en_b_n(en_b_n), .rst_in_n(rst_in_n), .cpu_clk(cpu_clk),
        .per_clk(per_clk), .ready_out(ready_out), .reset_out(reset_out)
    );

    // Pulse sources: crystal every 2 cycles, external every 3 cycles.
    initial begin
        int xc = 0;
        int ec = 0;
        forever begin
            @(negedge clk);
            xc = (xc + 1) % 2;
            ec = (ec + 1) % 3;
            xtal_tick = (xc == 0);
            ext_tick  = (ec == 0);
        end
    end

    // Waveform monitor.
    int cyc_since_rise = 0, last_period = 0, hi_run = 0, last_hi = 0, min_hi = 99;
    int per_cyc = 0, per_period = 0, per_run = 0, per_hi = 0;
    int ready_bad = 0;
    logic cp = 1'b0, pp = 1'b0, rp = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                cyc_since_rise++;
                if (cpu_clk && !cp) begin
                    last_period = cyc_since_rise;
                    cyc_since_rise = 0;
                end
                if (cpu_clk) hi_run = cp ? hi_run + 1 : 1;
                if (!cpu_clk && cp) begin
                    last_hi = hi_run;
                    if (hi_run < min_hi) min_hi = hi_run;
                end
                per_cyc++;
                if (per_clk && !pp) begin
                    per_period = per_cyc;
                    per_cyc = 0;
                end
                if (per_clk) per_run = pp ? per_run + 1 : 1;
                if (!per_clk && pp) per_hi = per_run;
                if ((ready_out != rp) && (cpu_clk == cp)) ready_bad++;
            end
            cp = cpu_clk;
            pp = per_clk;
            rp = ready_out;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state;
        wait_cyc(2);
        chk(cpu_clk == 1'b0,   "R10 cpu_clk in reset",   int'(cpu_clk), 0);
        chk(per_clk == 1'b0,   "R10 per_clk in reset",   int'(per_clk), 0);
        chk(ready_out == 1'b0, "R10 ready_out in reset", int'(ready_out), 0);
        chk(reset_out == 1'b1, "R10 reset_out in reset", int'(reset_out), 1);
    endtask

    task automatic t_xtal_div;
        src_sel = 1'b0;
        wait_cyc(60);
        chk(last_period == 6, "R1 R2 cpu period on crystal", last_period, 6);
        chk(last_hi == 2,     "R2 cpu high width on crystal", last_hi, 2);
        chk(per_period == 12, "R3 per period", per_period, 12);
        chk(per_hi == 6,      "R3 per high width", per_hi, 6);
    endtask

    task automatic t_ext_div;
        min_hi = 99;
        @(negedge clk);
        while (!cpu_clk) @(negedge clk);
        src_sel = 1'b1;
        wait_cyc(80);
        chk(last_period == 9, "R1 R2 cpu period on external", last_period, 9);
        chk(last_hi == 3,     "R2 cpu high width on external", last_hi, 3);
        chk(per_period == 18, "R3 per period on external", per_period, 18);
        chk(min_hi >= 2,      "R9 no short high phase after switch", min_hi, 2);
        min_hi = 99;
        @(negedge clk);
        while (cpu_clk) @(negedge clk);
        @(negedge clk);
        src_sel = 1'b0;
        wait_cyc(60);
        chk(min_hi >= 2,      "R9 no short high phase switching back", min_hi, 2);
        chk(last_period == 6, "R9 R1 crystal period restored", last_period, 6);
    endtask

    task automatic t_ready(input logic ra, input logic ea, input logic rb,
                           input logic eb, input logic exp, input string tag);
        rdy_a = ra; en_a_n = ea; rdy_b = rb; en_b_n = eb;
        wait_cyc(30);
        chk(ready_out == exp, tag, int'(ready_out), int'(exp));
    endtask

    task automatic t_ready_all;
        ready_bad = 0;
        t_ready(1, 0, 0, 1, 1'b1, "R4 only pair A active");
        t_ready(1, 1, 0, 0, 1'b0, "R4 A masked by enable, B not ready");
        t_ready(0, 1, 1, 0, 1'b1, "R4 only pair B active");
        t_ready(0, 0, 0, 0, 1'b0, "R4 both enabled, neither ready");
        t_ready(1, 0, 1, 0, 1'b1, "R4 both pairs active");
        t_ready(1, 1, 1, 1, 1'b0, "R4 both masked");
        chk(ready_bad == 0, "R5 ready moved without cpu_clk change", ready_bad, 0);
    endtask

    task automatic t_reset_long;
        int rises = 0;
        bit cprev;
        int guard = 0;
        chk(reset_out == 1'b0, "R8 reset released before test", int'(reset_out), 0);
        rst_in_n = 1'b0;
        wait_cyc(3);
        chk(reset_out == 1'b1, "R6 reset asserted within 3 cycles", int'(reset_out), 1);
        wait_cyc(40);
        rst_in_n = 1'b1;
        cprev = cpu_clk;
        while (reset_out && guard < 300) begin
            @(negedge clk);
            guard++;
            if (cpu_clk && !cprev) rises++;
            cprev = cpu_clk;
        end
        chk(rises >= 2 && rises <= 3, "R8 cpu rises after release", rises, 2);
    endtask

    task automatic t_reset_short;
        int rises = 0;
        bit cprev;
        int guard = 0;
        rst_in_n = 1'b0;
        wait_cyc(2);
        rst_in_n = 1'b1;
        while (!reset_out && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        chk(reset_out == 1'b1, "R6 short request asserts reset", int'(reset_out), 1);
        cprev = cpu_clk;
        guard = 0;
        while (reset_out && guard < 300) begin
            @(negedge clk);
            guard++;
            if (cpu_clk && !cprev) rises++;
            cprev = cpu_clk;
        end
        chk(rises >= 4 && rises <= 5, "R7 minimum reset length in cpu clocks", rises, 4);
    endtask

    initial begin
        t_reset_state();
        rst_n = 1'b1;
        wait_cyc(80);
        t_xtal_div();
        t_ready_all();
        t_reset_long();
        wait_cyc(10);
        t_reset_short();
        t_ext_div();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule